// File: doc/BRIEF.md
# Integer-N Synthesizer Divider and Phase-Frequency Detector

This block holds the digital half of an integer-N phase-locked loop that drives a dual-modulus prescaler. A reference counter divides incoming reference edges by a 14-bit ratio. A swallow counter and a main counter divide the prescaler output edges. While the swallow counter still has counts left, the block drives its modulus-select output high so the prescaler uses its larger ratio. The two divided pulses feed a phase-frequency detector, which produces pump-up and pump-down commands for an external charge pump.

The pump commands pass through an output stage before they leave the block. A 2-bit manual mode can force the pump up, force it down, switch it off or leave it under detector control. A polarity bit then swaps the up and down lines. The block also outputs a pump current code. This is the programmed normal code, where the actual current is (code + 1) × 0.625 mA, except while a fast-acquire window is open. During that window the code is a higher, parameter-set value. The window lasts a programmed number of time units, and each unit is a parameter-set number of clock cycles.

The inputs `ref_tick` and `pre_tick` are single-cycle pulses, one for each reference edge and one for each prescaler edge. The `cfg_we` pulse marks a write to a divider setting.

Top module: `pll_divpfd`

## Requirements
- R1: In the cycle after reset, `pump_up` and `pump_dn` are 0, `fa_active` is 0, `cur_code` equals `pump_code`, and `mod_hi` is 1 if and only if `a_cnt` is nonzero.
- R2: The reference divider issues one divided pulse for every `r_div` sampled `ref_tick` pulses. The allowed range of `r_div` is 3 to 16383. With the pump in detector mode, `pump_up` rises two clock edges after the edge that samples the `r_div`-th tick.
- R3: The feedback divider issues one divided pulse for every `b_cnt` sampled `pre_tick` pulses, with `b_cnt` ≥ 1 and `b_cnt` ≥ `a_cnt`. In detector mode, `pump_dn` rises two edges after the edge that samples the `b_cnt`-th tick.
- R4: `mod_hi` is 1 before each of the first `a_cnt` prescaler ticks of a cycle and 0 before each of the remaining `b_cnt`−`a_cnt` ticks. Both counters reload at the edge that takes the last tick, and `mod_hi` is high again after that edge.
- R5: The detector holds its up state until a divided feedback pulse arrives, and holds its down state until a divided reference pulse arrives. When both states would be set, it clears both. Up and down are never set together.
- R6: `pump_man` encodes the mode as 0 = detector, 1 = forced up, 2 = forced down, 3 = off. Mode 3 drives both pump outputs to 0.
- R7: When `pump_inv` = 1, the output stage swaps the up and down lines in every mode. When `pump_inv` = 0, the command goes out unchanged.
- R8: `cur_code` equals `pump_code` while `fa_active` = 0, and equals the parameter `FAST_CODE` (default 7) while `fa_active` = 1.
- R9: A `cfg_we` pulse sampled with `fa_en` = 1 and `fa_units` = U > 0 sets `fa_active` for exactly U × `UNIT_CYCLES` cycles (default 4 cycles per unit). With U = 0 the window does not open. Sampling `fa_en` = 0 closes an open window at the next edge.
- R10: A sampled `cfg_we` pulse restarts both dividers from their programmed values and clears both detector states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Divider setting written; restart strobe |
| ref_tick | input | 1 | One pulse per reference edge |
| pre_tick | input | 1 | One pulse per prescaler output edge |
| r_div | input | 14 | Reference division ratio |
| a_cnt | input | 3 | Swallow count (ticks at the larger modulus) |
| b_cnt | input | 13 | Main count (ticks per feedback pulse) |
| pump_man | input | 2 | Manual pump mode |
| pump_inv | input | 1 | Pump polarity swap |
| pump_code | input | 3 | Normal pump current code |
| fa_en | input | 1 | Fast-acquire enable |
| fa_units | input | 14 | Fast-acquire length in time units |
| pump_up | output | 1 | Pump-up command |
| pump_dn | output | 1 | Pump-down command |
| mod_hi | output | 1 | Prescaler modulus select (1 = larger ratio) |
| cur_code | output | 3 | Pump current code in effect |
| fa_active | output | 1 | Fast-acquire window open |

## Verification
Each divided pulse sits one register behind the tick edge, and the detector adds a second register. The pump outputs therefore answer two edges after the final tick, so the bench checks that they are still low one falling edge after that tick and high at the next one. The modulus select is read at the falling edge before each prescaler tick is driven. A restart and a detector clear both show up one edge after `cfg_we`. The fast-acquire window is counted in falling edges from the loading edge: it is checked open at U × `UNIT_CYCLES` − 1 and closed at U × `UNIT_CYCLES`. The manual and polarity stage is combinational, so its outputs are checked a short delay after the inputs change, away from any clock edge.

// File: rtl/pll_pkg.sv
package pll_pkg;

    localparam int REF_W  = 14;
    localparam int A_W    = 3;
    localparam int B_W    = 13;
    localparam int CODE_W = 3;
    localparam int FA_W   = 14;

    typedef enum logic [1:0] {
        MAN_PFD = 2'd0,
        MAN_UP  = 2'd1,
        MAN_DN  = 2'd2,
        MAN_OFF = 2'd3
    } man_mode_e;

    typedef struct packed {
        logic up;
        logic dn;
    } pump_cmd_t;

    // Manual override selects the command, then polarity swap applies.
    function automatic pump_cmd_t pump_shape(pump_cmd_t det, man_mode_e mode, logic inv);
        pump_cmd_t c;
        case (mode)
            MAN_UP:  c = '{up: 1'b1, dn: 1'b0};
            MAN_DN:  c = '{up: 1'b0, dn: 1'b1};
            MAN_OFF: c = '{up: 1'b0, dn: 1'b0};
            default: c = det;
        endcase
        if (inv) c = '{up: c.dn, dn: c.up};
        return c;
    endfunction

endpackage

// File: rtl/pll_refdiv.sv
module pll_refdiv #(
    parameter int W = pll_pkg::REF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         tick,
    input  logic [W-1:0] ratio,
    output logic         div_pulse
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        div_pulse <= 1'b0;
        if (rst || restart) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt >= ratio - W'(1)) begin
                cnt       <= '0;
                div_pulse <= 1'b1;
            end else begin
                cnt <= cnt + W'(1);
            end
        end
    end

    assert_ref_after_tick_R2: assert property (@(posedge clk) disable iff (rst)
        div_pulse |-> $past(tick));

endmodule

// File: rtl/pll_fbdiv.sv
module pll_fbdiv #(
    parameter int AW = pll_pkg::A_W,
    parameter int BW = pll_pkg::B_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          tick,
    input  logic [AW-1:0] a_val,
    input  logic [BW-1:0] b_val,
    output logic          mod_hi,
    output logic          div_pulse
);
    logic [AW-1:0] a_left;
    logic [BW-1:0] b_left;

    always_ff @(posedge clk) begin
        div_pulse <= 1'b0;
        if (rst || restart) begin
            a_left <= a_val;
            b_left <= b_val;
        end else if (tick) begin
            if (b_left <= BW'(1)) begin
                a_left    <= a_val;
                b_left    <= b_val;
                div_pulse <= 1'b1;
            end else begin
                b_left <= b_left - BW'(1);
                if (a_left != '0) a_left <= a_left - AW'(1);
            end
        end
    end

    assign mod_hi = (a_left != '0);

    assert_fb_after_tick_R3: assert property (@(posedge clk) disable iff (rst)
        div_pulse |-> $past(tick));

    assert_mod_drop_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(mod_hi) |-> $past(tick));

endmodule

// File: rtl/pll_pfd.sv
module pll_pfd (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                ref_edge,
    input  logic                fb_edge,
    output pll_pkg::pump_cmd_t  det
);
    logic up_q, dn_q, up_n, dn_n;

    always_comb begin
        up_n = up_q | ref_edge;
        dn_n = dn_q | fb_edge;
        if (up_n && dn_n) begin
            up_n = 1'b0;
            dn_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else begin
            up_q <= up_n;
            dn_q <= dn_n;
        end
    end

    assign det = '{up: up_q, dn: dn_q};

    assert_pfd_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(up_q && dn_q));

    assert_pfd_up_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (up_q && !fb_edge && !clear) |=> up_q);

endmodule

// File: rtl/pll_fastacq.sv
module pll_fastacq #(
    parameter int FW         = pll_pkg::FA_W,
    parameter int UNIT_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          trigger,
    input  logic          enable,
    input  logic [FW-1:0] units,
    output logic          active
);
    localparam int SW = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
    localparam logic [SW-1:0] SUB_TOP = SW'(UNIT_CYCLES - 1);

    logic [FW-1:0] units_left;
    logic [SW-1:0] sub;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            units_left <= '0;
            sub        <= '0;
        end else if (trigger) begin
            units_left <= units;
            sub        <= SUB_TOP;
        end else if (units_left != '0) begin
            if (sub == '0) begin
                sub        <= SUB_TOP;
                units_left <= units_left - FW'(1);
            end else begin
                sub <= sub - SW'(1);
            end
        end
    end

    assign active = (units_left != '0);

    assert_fa_abort_R9: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !active);

    assert_fa_open_on_trigger_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(trigger && enable));

endmodule

// File: rtl/pll_divpfd.sv
module pll_divpfd #(
    parameter int REF_W       = pll_pkg::REF_W,
    parameter int A_W         = pll_pkg::A_W,
    parameter int B_W         = pll_pkg::B_W,
    parameter int CODE_W      = pll_pkg::CODE_W,
    parameter int FA_W        = pll_pkg::FA_W,
    parameter int UNIT_CYCLES = 4,
    parameter int FAST_CODE   = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              ref_tick,
    input  logic              pre_tick,
    input  logic [REF_W-1:0]  r_div,
    input  logic [A_W-1:0]    a_cnt,
    input  logic [B_W-1:0]    b_cnt,
    input  logic [1:0]        pump_man,
    input  logic              pump_inv,
    input  logic [CODE_W-1:0] pump_code,
    input  logic              fa_en,
    input  logic [FA_W-1:0]   fa_units,
    output logic              pump_up,
    output logic              pump_dn,
    output logic              mod_hi,
    output logic [CODE_W-1:0] cur_code,
    output logic              fa_active
);
    import pll_pkg::*;

    localparam logic [CODE_W-1:0] FAST_C = CODE_W'(FAST_CODE);

    logic      ref_edge, fb_edge;
    pump_cmd_t det, shaped;

    pll_refdiv #(.W(REF_W)) u_ref (
        .clk(clk), .rst(rst), .restart(cfg_we), .tick(ref_tick),
        .ratio(r_div), .div_pulse(ref_edge)
    );

    pll_fbdiv #(.AW(A_W), .BW(B_W)) u_fb (
        .clk(clk), .rst(rst), .restart(cfg_we), .tick(pre_tick),
        .a_val(a_cnt), .b_val(b_cnt), .mod_hi(mod_hi), .div_pulse(fb_edge)
    );

    pll_pfd u_pfd (
        .clk(clk), .rst(rst), .clear(cfg_we),
        .ref_edge(ref_edge), .fb_edge(fb_edge), .det(det)
    );

    pll_fastacq #(.FW(FA_W), .UNIT_CYCLES(UNIT_CYCLES)) u_fa (
        .clk(clk), .rst(rst), .trigger(cfg_we), .enable(fa_en),
        .units(fa_units), .active(fa_active)
    );

    always_comb begin
        shaped   = pump_shape(det, man_mode_e'(pump_man), pump_inv);
        pump_up  = shaped.up;
        pump_dn  = shaped.dn;
        cur_code = fa_active ? FAST_C : pump_code;
    end

    assert_man_off_R6: assert property (@(posedge clk) disable iff (rst)
        (pump_man == 2'd3) |-> (!pump_up && !pump_dn));

    assert_restart_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && pump_man == 2'd0) |=> (pump_man != 2'd0 || (!pump_up && !pump_dn)));

endmodule

// File: tb/pll_divpfd_tb.sv
module pll_divpfd_tb_top;

    logic        clk = 1'b0;
    logic        rst, cfg_we, ref_tick, pre_tick, pump_inv, fa_en;
    logic [13:0] r_div, fa_units;
    logic [2:0]  a_cnt, pump_code;
    logic [12:0] b_cnt;
    logic [1:0]  pump_man;
    logic        pump_up, pump_dn, mod_hi, fa_active;
    logic [2:0]  cur_code;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pll_divpfd dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .ref_tick(ref_tick), .pre_tick(pre_tick),
        .r_div(r_div), .a_cnt(a_cnt), .b_cnt(b_cnt), .pump_man(pump_man),
        .pump_inv(pump_inv), .pump_code(pump_code), .fa_en(fa_en), .fa_units(fa_units),
        .pump_up(pump_up), .pump_dn(pump_dn), .mod_hi(mod_hi), .cur_code(cur_code),
        .fa_active(fa_active)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_cfg();
        @(negedge clk) cfg_we = 1'b1;
        @(negedge clk) cfg_we = 1'b0;
    endtask

    task automatic pulse_ref();
        @(negedge clk) ref_tick = 1'b1;
        @(negedge clk) ref_tick = 1'b0;
    endtask

    task automatic pulse_pre();
        @(negedge clk) pre_tick = 1'b1;
        @(negedge clk) pre_tick = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 up", pump_up, 0);
        chk("R1 dn", pump_dn, 0);
        chk("R1 fa_active", fa_active, 0);
        chk("R1 cur_code", cur_code, 5);
        chk("R1 mod_hi", mod_hi, 1);
    endtask

    task automatic t_refdiv();
        pulse_cfg();
        pulse_ref(); pulse_ref();
        @(negedge clk);
        chk("R2 no up before ratio", pump_up, 0);
        pulse_ref();
        chk("R2 up one edge after last tick", pump_up, 0);
        @(negedge clk);
        chk("R2 up two edges after last tick", pump_up, 1);
        pulse_cfg();
        chk("R10 restart clears up", pump_up, 0);
    endtask

    task automatic t_fbdiv();
        pulse_cfg();
        for (int i = 0; i < 5; i++) begin
            chk($sformatf("R4 mod_hi before tick %0d", i + 1), mod_hi, (i < 2) ? 1 : 0);
            pulse_pre();
        end
        chk("R4 mod_hi after reload", mod_hi, 1);
        chk("R3 dn one edge after last tick", pump_dn, 0);
        @(negedge clk);
        chk("R3 dn two edges after last tick", pump_dn, 1);
        chk("R5 up low while dn", pump_up, 0);
        pulse_cfg();
        chk("R10 restart clears dn", pump_dn, 0);
    endtask

    task automatic t_pfd_cancel();
        pulse_cfg();
        pulse_ref(); pulse_ref(); pulse_ref();
        @(negedge clk);
        for (int i = 0; i < 4; i++) pulse_pre();
        chk("R5 up held until feedback", pump_up, 1);
        pulse_pre();
        @(negedge clk);
        chk("R5 both cleared up", pump_up, 0);
        chk("R5 both cleared dn", pump_dn, 0);
    endtask

    task automatic t_manual();
        pulse_cfg();
        @(negedge clk) pump_man = 2'd1; #1;
        chk("R6 forced up", {pump_up, pump_dn}, 2'b10);
        pump_man = 2'd2; #1;
        chk("R6 forced down", {pump_up, pump_dn}, 2'b01);
        pump_man = 2'd0;
        pulse_ref(); pulse_ref(); pulse_ref();
        @(negedge clk);
        chk("R6 detector mode up", {pump_up, pump_dn}, 2'b10);
        pump_man = 2'd3; #1;
        chk("R6 off masks pending up", {pump_up, pump_dn}, 2'b00);
        pump_man = 2'd0; pump_inv = 1'b1; #1;
        chk("R7 inverted detector up", {pump_up, pump_dn}, 2'b01);
        pump_man = 2'd1; #1;
        chk("R7 inverted forced up", {pump_up, pump_dn}, 2'b01);
        pump_man = 2'd0; pump_inv = 1'b0; #1;
        chk("R7 no invert", {pump_up, pump_dn}, 2'b10);
        pulse_cfg();
    endtask

    task automatic t_fast();
        fa_en = 1'b1; fa_units = 14'd3;
        pulse_cfg();
        chk("R9 window opens", fa_active, 1);
        chk("R8 fast code", cur_code, 7);
        repeat (11) @(negedge clk);
        chk("R9 open at last cycle", fa_active, 1);
        @(negedge clk);
        chk("R9 closed after 12 cycles", fa_active, 0);
        chk("R8 normal code back", cur_code, 5);
        fa_units = 14'd0;
        pulse_cfg();
        chk("R9 zero units no window", fa_active, 0);
        fa_units = 14'd3;
        pulse_cfg();
        @(negedge clk) fa_en = 1'b0;
        @(negedge clk);
        chk("R9 disable aborts", fa_active, 0);
        fa_en = 1'b1;
        pulse_cfg();
        fa_en = 1'b0;
        @(negedge clk);
        chk("R9 restart without enable", fa_active, 0);
    endtask

    initial begin
        rst = 1'b1; cfg_we = 1'b0; ref_tick = 1'b0; pre_tick = 1'b0;
        r_div = 14'd3; a_cnt = 3'd2; b_cnt = 13'd5;
        pump_man = 2'd0; pump_inv = 1'b0; pump_code = 3'd5;
        fa_en = 1'b0; fa_units = 14'd0;
        t_reset();
        t_refdiv();
        t_fbdiv();
        t_pfd_cancel();
        t_manual();
        t_fast();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog actual=expired expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule